// File: doc/BRIEF.md
# Four-Phase Turbo Interleaver Address Generator

This block produces the interleaved read addresses for a duo-binary turbo decoder whose permutation repeats a pattern of four offsets. Software or a control block first loads the block length N and the four permutation constants. A start pulse then makes the block emit the addresses for i = 0 through N-1, one per accepted transfer on a valid/ready output. When the last address has been taken, a done flag goes high.

No multiplier or divider is used. A base accumulator moves forward by the first constant on each step and is reduced by one conditional subtraction of N. The offset for the current phase is chosen by a two-bit phase counter. The three non-zero offsets are reduced modulo N once, at load time, so the output path needs only one adder and one compare-and-subtract.

Top module: `arp_addr_gen`

## Requirements
- R1: After reset, `out_valid` and `done` are low, and they stay low until a start pulse arrives.
- R2: For step i with i mod 4 = 0, `out_addr` equals (P0*i + 1) mod N.
- R3: For step i with i mod 4 = 1, `out_addr` equals (P0*i + 1 + N/2 + P1) mod N.
- R4: For step i with i mod 4 = 2, `out_addr` equals (P0*i + 1 + P2) mod N.
- R5: For step i with i mod 4 = 3, `out_addr` equals (P0*i + 1 + N/2 + P3) mod N.
- R6: Whenever `out_valid` is high, `out_addr` is less than N.
- R7: The step index advances only on a cycle where `out_valid` and `out_ready` are both high. While the output is stalled, `out_valid` stays high and `out_addr` holds its value.
- R8: Exactly N addresses are transferred per sequence. In the cycle after the last transfer, `out_valid` falls and `done` rises. For N a multiple of 8, P0 odd and coprime with N, and P1, P2, P3 multiples of 4, the N addresses are a permutation of 0..N-1.
- R9: While a sequence is running, `start` and `cfg_load` are ignored. The sequence in progress continues with its original constants.
- R10: A start pulse while idle clears `done` in the next cycle and begins a new sequence at i = 0, so the first address is 1. It reuses the constants already loaded, without a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Captures the cfg_* values when idle |
| cfg_n | input | AW | Block length N (even, at least 8) |
| cfg_p0 | input | AW | Base step constant, less than N |
| cfg_p1 | input | AW | Phase-1 constant, less than N |
| cfg_p2 | input | AW | Phase-2 constant, less than N |
| cfg_p3 | input | AW | Phase-3 constant, less than N |
| start | input | 1 | Begins a sequence when idle |
| out_ready | input | 1 | Consumer accepts the current address |
| out_valid | output | 1 | An address is presented |
| out_addr | output | AW | Interleaved address for the current step |
| done | output | 1 | High after the last address of a sequence was taken |

## Verification
Each sequence is swept completely, from a tiny N = 8 up to N = 6144, with every address compared against the closed-form modular expression. This separates the four phase formulas, because each phase uses a different constant, and it also exposes a missed or doubled reduction, which shows up once the accumulator wraps. A pseudo-random ready pattern tells advance-on-accept apart from advance-every-cycle. A pulse of start and cfg_load with different constants in the middle of a run shows whether commands are really ignored while busy. A second run without reload, together with a bitmap check that every address appears exactly once, confirms the restart value and the exact count of N.

// File: rtl/arp_addr_gen.sv
module arp_addr_gen #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_n,
  input  logic [AW-1:0] cfg_p0,
  input  logic [AW-1:0] cfg_p1,
  input  logic [AW-1:0] cfg_p2,
  input  logic [AW-1:0] cfg_p3,
  input  logic          start,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          done
);

  function automatic logic [AW-1:0] add_mod(input logic [AW-1:0] a,
                                            input logic [AW-1:0] b,
                                            input logic [AW-1:0] m);
    logic [AW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, m}) s = s - {1'b0, m};
    return s[AW-1:0];
  endfunction

  logic [AW-1:0] n_q, p0_q, off1_q, off2_q, off3_q;
  logic [AW-1:0] base_q, cnt_q, off_sel;
  logic [1:0]    ph_q;
  logic          run_q, done_q;

  wire fire = run_q & out_ready;
  wire last = (cnt_q == n_q - 1'b1);

  always_comb begin
    case (ph_q)
      2'd1:    off_sel = off1_q;
      2'd2:    off_sel = off2_q;
      2'd3:    off_sel = off3_q;
      default: off_sel = '0;
    endcase
  end

  assign out_valid = run_q;
  assign out_addr  = add_mod(base_q, off_sel, n_q);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q    <= '0;
      p0_q   <= '0;
      off1_q <= '0;
      off2_q <= '0;
      off3_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      ph_q   <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (cfg_load && !run_q) begin
        n_q    <= cfg_n;
        p0_q   <= cfg_p0;
        off1_q <= add_mod(cfg_n >> 1, cfg_p1, cfg_n);
        off2_q <= cfg_p2;
        off3_q <= add_mod(cfg_n >> 1, cfg_p3, cfg_n);
      end
      if (start && !run_q) begin
        base_q <= AW'(1);
        cnt_q  <= '0;
        ph_q   <= '0;
        run_q  <= 1'b1;
        done_q <= 1'b0;
      end else if (fire) begin
        base_q <= add_mod(base_q, p0_q, n_q);
        cnt_q  <= cnt_q + 1'b1;
        ph_q   <= ph_q + 1'b1;
        if (last) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/arp_addr_gen_chk.sv
module arp_addr_gen_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          out_ready,
  input logic          out_valid,
  input logic [AW-1:0] out_addr,
  input logic          done,
  input logic [AW-1:0] n_q
);

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr < n_q); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr)); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && out_valid)); // R8

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && start && !out_ready |=> out_valid); // R9

  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_addr == AW'(1)); // R10

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !done); // R10

endmodule

bind arp_addr_gen arp_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
  .out_valid(out_valid), .out_addr(out_addr), .done(done), .n_q(n_q)
);

// File: tb/arp_addr_gen_tb.sv
`timescale 1ns/1ps
module arp_addr_gen_tb;
  localparam int AW = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [AW-1:0] cfg_n = '0, cfg_p0 = '0, cfg_p1 = '0, cfg_p2 = '0, cfg_p3 = '0;
  logic out_valid, done;
  logic [AW-1:0] out_addr;

  int nt = 0, nf = 0;
  bit seen [0:8191];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  arp_addr_gen #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_n(cfg_n),
    .cfg_p0(cfg_p0), .cfg_p1(cfg_p1), .cfg_p2(cfg_p2), .cfg_p3(cfg_p3),
    .start(start), .out_ready(out_ready), .out_valid(out_valid),
    .out_addr(out_addr), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nt++;
    if (!ok) begin
      nf++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n, input int p0, input int p1, input int p2, input int p3,
                     input bit reload, input bit stall, input bit disturb);
    int idx = 0;
    int guard = 0;
    bit first = 1'b1;
    if (reload) begin
      @(negedge clk);
      cfg_n = AW'(n); cfg_p0 = AW'(p0); cfg_p1 = AW'(p1); cfg_p2 = AW'(p2); cfg_p3 = AW'(p3);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
    end
    for (int k = 0; k < 8192; k++) seen[k] = 1'b0;
    @(negedge clk);
    start = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0;
      cfg_load = 1'b0;
      if (first) begin
        chk(out_valid == 1'b1 && done == 1'b0, "R10 start clears done", {out_valid, done}, 2);
        chk(out_addr == AW'(1), "R10 first address", out_addr, 1);
        first = 1'b0;
      end
      if (!out_valid) break;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      if (out_ready) begin
        int ph = idx % 4;
        longint q = (ph == 1) ? n / 2 + p1 : (ph == 2) ? p2 : (ph == 3) ? n / 2 + p3 : 0;
        longint exp = (longint'(p0) * idx + 1 + q) % n;
        case (ph)
          0: chk(out_addr == exp, "R2 phase 0 address", out_addr, exp);
          1: chk(out_addr == exp, "R3 phase 1 address", out_addr, exp);
          2: chk(out_addr == exp, "R4 phase 2 address", out_addr, exp);
          default: chk(out_addr == exp, "R5 phase 3 address", out_addr, exp);
        endcase
        if (out_addr < n) seen[out_addr] = 1'b1;
        idx++;
        if (disturb && idx == n / 2) begin
          start = 1'b1;
          cfg_load = 1'b1;
          cfg_n = AW'(16); cfg_p0 = AW'(3); cfg_p1 = AW'(5); cfg_p2 = AW'(7); cfg_p3 = AW'(9);
        end
      end
      guard++;
      if (guard > 40000) begin
        chk(1'b0, "R8 sequence never ended", idx, n);
        break;
      end
    end
    chk(idx == n, "R8 transfer count", idx, n);
    chk(done == 1'b1, "R8 done after last", done, 1);
    begin
      int miss = 0;
      for (int k = 0; k < n; k++) if (!seen[k]) miss++;
      chk(miss == 0, "R8 permutation coverage", miss, 0);
    end
    if (disturb) chk(idx == n, "R9 busy commands ignored", idx, n);
    out_ready = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R1 reset state", {out_valid, done}, 0);
    rst_n = 1'b1;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R1 idle without start", {out_valid, done}, 0);
    out_ready = 1'b0;
    run(8, 3, 4, 0, 4, 1'b1, 1'b0, 1'b0);
    run(24, 5, 4, 8, 12, 1'b1, 1'b1, 1'b0);
    run(48, 7, 24, 4, 44, 1'b1, 1'b1, 1'b1);
    run(48, 7, 24, 4, 44, 1'b0, 1'b0, 1'b0);
    run(6144, 13, 24, 44, 100, 1'b1, 1'b0, 1'b0);
    run(6144, 4097, 6140, 6136, 3076, 1'b1, 1'b1, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule